// File: doc/BRIEF.md
# Coarse Reciprocal Seed for Logarithm Range Reduction

This unit takes one single-precision float per beat and returns a rough float estimate of the reciprocal of that input's significand. The input exponent and sign are discarded. The leading fraction bits of the input form a small index. Each index selects a short reciprocal constant. The result is always a positive float whose unbiased exponent is zero, so it lies in [1,2). Only the leading few significand bits of the result can be nonzero. A logarithm routine multiplies its reduced argument by this seed, and it keeps the logarithm of the seed in a matching table of its own.

Inputs equal to zero, denormals, infinities and NaNs are not meaningful to the reduction. Each of them yields exactly +1.0 (0x3F800000).

Both sides of the unit are valid/ready streams with a single output register between them. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. A beat leaves on a clock edge where `out_valid` and `out_ready` are both high. While the output beat is stalled, it stays unchanged. `in_ready` is high whenever the output register is empty or is being drained on the same edge. Because of that, a downstream that always accepts sees one result per cycle.

Top module: `crcp_log_recip`

## Requirements
- R1: For an input whose biased exponent field (bits 30:23) is neither 0 nor 255, let i be input bits 22:19 read as an unsigned number. The output is {sign 0, exponent field 127, bits 22:19 = f, bits 18:0 = 0}, where f = floor(16 * (64/(33+2i) - 1)), clamped to at most 15.
- R2: Every valid output has sign bit 31 equal to 0 and exponent field bits 30:23 equal to 127, whatever the input sign and exponent are.
- R3: Every valid output has bits 18:0 equal to zero.
- R4: An input whose exponent field is 0 (zero or denormal, either sign) produces exactly 0x3F800000.
- R5: An input whose exponent field is 255 (infinity or NaN, either sign) produces exactly 0x3F800000.
- R6: Input fraction bits 18:0 have no effect on the output.
- R7: A beat accepted on a clock edge is presented on `out_data`, with `out_valid` high, directly after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_data` hold. Otherwise `in_ready` is high. When the output drains and no new beat is accepted, `out_valid` falls.
- R9: While `rst_n` is low, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can accept an input beat |
| in_data | input | 32 | Single-precision input |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 32 | Single-precision reciprocal seed |

## Verification
Each accepted beat's result is due one edge after acceptance. A stalled result stays due, unchanged, until the edge on which `out_ready` is high. The bench keeps a one-entry model of the output register. It updates the model with the same acceptance and drain rules stated in R7 and R8, using the inputs it drove for the coming edge. On the following falling edge it compares `out_valid`, `out_data` and `in_ready` with the model. The stall pattern comes from random `out_ready` values, so both the one-cycle path and the held path are sampled repeatedly.

// File: rtl/crcp_pkg.sv
package crcp_pkg;

  localparam int unsigned FP_EXP_W = 8;
  localparam int unsigned FP_MAN_W = 23;
  localparam int unsigned FP_BIAS  = 127;

  typedef logic [FP_EXP_W-1:0] fp_exp_t;

  // Truncated fraction of 2/(1+(idx+0.5)/2^ib), keeping fb fraction bits.
  // Written as floor(2^fb * (2^(ib+1)-2idx-1) / (2^(ib+1)+2idx+1)).
  function automatic int unsigned seed_frac(int unsigned idx, int unsigned ib,
                                            int unsigned fb);
    longint unsigned num;
    longint unsigned den;
    longint unsigned q;
    longint unsigned lim;
    num = ((longint'(1) << (ib + 1)) - 2 * longint'(idx) - 1) << fb;
    den = (longint'(1) << (ib + 1)) + 2 * longint'(idx) + 1;
    q   = num / den;
    lim = (longint'(1) << fb) - 1;
    if (q > lim) q = lim;
    return int'(q);
  endfunction

endpackage

// File: rtl/crcp_classify.sv
module crcp_classify
  import crcp_pkg::*;
(
  input  fp_exp_t exp_field,
  output logic    is_special
);
  localparam fp_exp_t EXP_ALL1 = '1;

  logic is_zero_or_sub;
  logic is_inf_or_nan;

  always_comb begin
    is_zero_or_sub = (exp_field == '0);
    is_inf_or_nan  = (exp_field == EXP_ALL1);
    is_special     = is_zero_or_sub | is_inf_or_nan;
  end
endmodule

// File: rtl/crcp_lut.sv
module crcp_lut #(
  parameter int unsigned IDX_BITS  = 4,
  parameter int unsigned FRAC_BITS = 4
) (
  input  logic [IDX_BITS-1:0]  idx,
  output logic [FRAC_BITS-1:0] frac
);
  import crcp_pkg::*;

  localparam int unsigned DEPTH = 1 << IDX_BITS;

  logic [FRAC_BITS-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int unsigned VAL = seed_frac(g, IDX_BITS, FRAC_BITS);
    assign rom[g] = FRAC_BITS'(VAL);
  end

  assign frac = rom[idx];
endmodule

// File: rtl/crcp_stage.sv
module crcp_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign s_ready = !v_q || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (s_valid && s_ready) begin
      v_q <= 1'b1;
      d_q <= s_data;
    end else if (m_ready) begin
      v_q <= 1'b0;
    end
  end

  assign m_valid = v_q;
  assign m_data  = d_q;
endmodule

// File: rtl/crcp_log_recip.sv
module crcp_log_recip #(
  parameter int unsigned IDX_BITS  = 4,
  parameter int unsigned KEEP_BITS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data
);
  import crcp_pkg::*;

  localparam int unsigned FRAC_BITS = KEEP_BITS - 1;
  localparam int unsigned PAD_BITS  = FP_MAN_W - FRAC_BITS;
  localparam int unsigned LOW_BITS  = FP_MAN_W - IDX_BITS;
  localparam fp_exp_t     ZERO_EXP  = fp_exp_t'(FP_BIAS);
  localparam logic [31:0] ONE_WORD  = {1'b0, ZERO_EXP, {FP_MAN_W{1'b0}}};

  fp_exp_t              exp_field;
  logic [IDX_BITS-1:0]  idx;
  logic [FRAC_BITS-1:0] frac;
  logic                 is_special;
  logic [31:0]          seed_word;
  logic                 unused_bits;

  assign exp_field   = in_data[FP_MAN_W +: FP_EXP_W];
  assign idx         = in_data[LOW_BITS +: IDX_BITS];
  assign unused_bits = ^{in_data[31], in_data[LOW_BITS-1:0]};

  crcp_classify u_class (
    .exp_field  (exp_field),
    .is_special (is_special)
  );

  crcp_lut #(
    .IDX_BITS  (IDX_BITS),
    .FRAC_BITS (FRAC_BITS)
  ) u_lut (
    .idx  (idx),
    .frac (frac)
  );

  always_comb begin
    if (is_special) seed_word = ONE_WORD;
    else            seed_word = {1'b0, ZERO_EXP, frac, {PAD_BITS{1'b0}}};
  end

  crcp_stage #(
    .W (32)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (seed_word),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_data)
  );
endmodule

// File: rtl/crcp_log_recip_chk.sv
module crcp_log_recip_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  assert_exp_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[31] == 1'b0 && out_data[30:23] == 8'd127));

  assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[18:0] == 19'd0));

  assert_zero_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data[30:23] == 8'd0) |=> (out_data == 32'h3F80_0000));

  assert_inf_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data[30:23] == 8'hFF) |=> (out_data == 32'h3F80_0000));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind crcp_log_recip crcp_log_recip_chk chk_i (.*);

// File: tb/crcp_log_recip_tb.sv
`timescale 1ns/1ps
module crcp_log_recip_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  crcp_log_recip dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // Expected result from R1/R4/R5, computed with real arithmetic.
  function automatic logic [31:0] ref_seed(logic [31:0] x);
    int   i;
    real  r;
    int   f;
    if (x[30:23] == 8'd0 || x[30:23] == 8'hFF) return 32'h3F80_0000;
    i = int'(x[22:19]);
    r = 16.0 * (64.0 / real'(33 + 2 * i) - 1.0);
    f = int'($floor(r));
    if (f > 15) f = 15;
    return {1'b0, 8'd127, 4'(f), 19'd0};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One-entry model of the output register.
  logic        m_valid = 1'b0;
  logic [31:0] m_data = '0;

  task automatic step(logic v, logic [31:0] d, logic rdy);
    logic [31:0] e;
    bit          acc;
    // Compare the state left by the previous edge.
    check(out_valid == m_valid, "R7 R8 out_valid", 32'(out_valid), 32'(m_valid));
    check(in_ready == (!m_valid || out_ready), "R8 in_ready",
          32'(in_ready), 32'(!m_valid || out_ready));
    if (m_valid) begin
      check(out_data == m_data, "R1 R4 R5 R6 out_data", out_data, m_data);
      check(out_data[31:23] == 9'h07F, "R2 sign/exp", 32'(out_data[31:23]), 32'h7F);
      check(out_data[18:0] == 19'd0, "R3 low bits", 32'(out_data[18:0]), 32'd0);
    end
    // Drive inputs for the next edge and advance the model.
    in_valid  = v;
    in_data   = d;
    out_ready = rdy;
    acc = v && (!m_valid || rdy);
    e = ref_seed(d);
    if (acc) begin
      m_valid = 1'b1;
      m_data  = e;
    end else if (rdy) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] dir [0:13];
    int unsigned seed;
    seed = $urandom(32'd1234);
    dir[0]  = 32'h0000_0000; dir[1]  = 32'h8000_0000; dir[2]  = 32'h0000_0001;
    dir[3]  = 32'h807F_FFFF; dir[4]  = 32'h7F80_0000; dir[5]  = 32'hFF80_0000;
    dir[6]  = 32'h7FC0_0000; dir[7]  = 32'h7F80_0001; dir[8]  = 32'h3F80_0000;
    dir[9]  = 32'hC2F8_0000; dir[10] = 32'h0080_0000; dir[11] = 32'h7F7F_FFFF;
    dir[12] = 32'h3FF8_0000; dir[13] = 32'h3FFF_FFFF;

    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid", 32'(out_valid), 32'd0);
    check(out_data == 32'd0, "R9 out_data", out_data, 32'd0);
    check(in_ready == 1'b1, "R9 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases, downstream always ready.
    for (int k = 0; k < 14; k++) step(1'b1, dir[k], 1'b1);
    // Every index with exponent and low bits varied (R1, R6).
    for (int i = 0; i < 16; i++) begin
      step(1'b1, {1'b0, 8'd127, 4'(i), 19'd0}, 1'b1);
      step(1'b1, {1'b1, 8'd3, 4'(i), 19'h7FFFF}, 1'b1);
      step(1'b1, {1'b0, 8'd254, 4'(i), 19'h2A5A5}, 1'b1);
    end
    // Explicit R6: same index, different low bits, one known value.
    step(1'b1, 32'h4000_0000, 1'b1);
    check(out_data == 32'h3FF8_0000, "R6 base", out_data, 32'h3FF8_0000);
    step(1'b1, 32'h4007_FFFF, 1'b1);
    check(out_data == 32'h3FF8_0000, "R6 low bits", out_data, 32'h3FF8_0000);
    // Stall: hold for several cycles (R8), then drain.
    step(1'b1, 32'h41F0_0000, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 32'h7F80_0000, 1'b0);
    step(1'b0, 32'h0, 1'b1);
    step(1'b0, 32'h0, 1'b1);
    check(out_valid == 1'b0, "R8 drained", 32'(out_valid), 32'd0);

    // Constrained random traffic with random back-pressure.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d;
      int          pick;
      d = $urandom;
      pick = int'($urandom_range(0, 9));
      if (pick == 0) d[30:23] = 8'd0;
      else if (pick == 1) d[30:23] = 8'hFF;
      step(($urandom_range(0, 3) != 0), d, ($urandom_range(0, 2) != 0));
    end
    step(1'b0, 32'h0, 1'b1);
    step(1'b0, 32'h0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule